// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. A command (address, read/write select, chip selects and load/advance strobe) is sampled on a rising clock edge. Its data transfer happens in the following cycle. Read data flows straight from the storage array to the output with no output register. Write data is sampled at the end of the data cycle. Reads and writes can be issued back to back in either order, and the data bus never needs an idle cycle to turn around.

A four-beat burst generator produces the addresses that follow a loaded start address, in either linear (wrapping increment) or interleaved (XOR) order. A clock enable freezes the whole pipeline. Three chip selects gate new commands. Per-lane write selects mask byte lanes of nine bits each. An asynchronous output enable and a sleep input complete the control set. The bidirectional data bus is presented as separate input, output and output-enable ports. The storage depth is a parameter and is kept small for simulation.

Top module: `zt_sram`

## Requirements
- R1: A read command sampled on an enabled edge drives the addressed word on `d_out` with `d_oe` high during the next cycle. The value is taken combinationally from the array.
- R2: Write data on `d_in` is sampled on the enabled edge that ends the data cycle of a write command.
- R3: `oe_n` high forces `d_oe` low in the same cycle, whatever the pipeline holds.
- R4: While `cen_n` is high, all command inputs and `d_in` are ignored. The pending command, its data cycle and the burst state are held, and no array write occurs.
- R5: A new command starts only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 on an enabled edge with `adv`=0. Any other select combination on such an edge deselects the block, and `d_oe` is low in the next cycle. A write whose data cycle is still in the pipeline completes regardless.
- R6: `d_oe` is low during the data cycle of a write command.
- R7: Write and read commands on consecutive cycles run without a dead bus cycle. The read data cycle follows the write data cycle directly.
- R8: Lane k of the data word is bits [9k+8:9k]. That lane is written only if `bw_n[k]`=0 in the command (or burst advance) cycle.
- R9: With `adv`=1 after a loaded command, the block steps through four beats, then wraps to the start address. With `lin_order`=1 the low two address bits are (start+n) mod 4. With `lin_order`=0 they are start XOR n. The upper bits stay fixed.
- R10: An advance continues the operation type of the loaded command and ignores `rd_nwr`. An advance while deselected keeps the block idle.
- R11: While `sleep`=1, enabled edges start no command and the next cycle is idle. Stored data is kept, and a write already in its data cycle completes.
- R12: A read of an address issued the cycle after a write to it returns the newly written value.
- R13: After reset the block is idle with `d_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; high stalls the block |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 advances the burst, 0 loads a new command |
| rd_nwr | input | 1 | 1 read, 0 write |
| addr | input | AW | Word address |
| bw_n | input | LANES | Per-lane write selects, active low |
| lin_order | input | 1 | 1 linear burst order, 0 interleaved |
| sleep | input | 1 | Power-down request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data from the bus |
| d_out | output | LANES*LANE_W | Read data toward the bus |
| d_oe | output | 1 | Bus drive enable |

## Verification
The bench writes every address and reads it back on the very next cycle. A design that buffered write data one edge too late, or inserted a turnaround cycle, would return stale words or drop `d_oe` between them. All sixteen lane masks are applied over a known background, which catches a lane map that is swapped or shifted. Bursts from every start offset run in both orders and past the wrap, so a wrong carry into the upper address bits or a missing wrap reads the wrong word. Stall, deselect, sleep and output-enable cycles are placed on top of pending reads and writes. A design that let `d_in` through during a stall, dropped a pending write on deselect or sleep, or registered `oe_n` would miscompare or drive the bus in the wrong cycle.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_INCR = 1'b1
  } zt_order_e;

  localparam int unsigned BEATS = 4;

  // Low two address bits of beat n of a burst starting at 'start'.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input zt_order_e  ord);
    logic [1:0] r;
    if (ord == ORD_INCR) r = start + n;
    else                 r = start ^ n;
    return r;
  endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_addr,
  input  zt_order_e     ord,
  output logic [AW-1:0] nxt_addr
);

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [1:0]    cnt_inc;

  assign cnt_inc  = cnt_q + 2'd1;
  assign nxt_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_inc, ord)};

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = ld_addr;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  p_burst_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0));
  p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             sleep,
  input  logic             sel_ok,
  input  logic             adv,
  input  logic             rd_nwr,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  input  zt_order_e        ord,
  output logic             vld,
  output logic             wr,
  output logic [AW-1:0]    cur_addr,
  output logic [LANES-1:0] cur_be
);

  logic             en;
  logic             load, step;
  logic [AW-1:0]    burst_addr;
  logic             vld_q, vld_d;
  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [LANES-1:0] be_q, be_d;

  assign en   = ~cen_n;
  assign load = en & ~sleep & ~adv & sel_ok;
  assign step = en & ~sleep & adv & act_q;

  zt_burst_gen #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .ld_addr  (addr),
    .ord      (ord),
    .nxt_addr (burst_addr)
  );

  always_comb begin
    vld_d  = vld_q;
    act_d  = act_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    be_d   = be_q;
    if (en) begin
      if (sleep) begin
        vld_d = 1'b0;
        act_d = 1'b0;
      end else if (!adv) begin
        if (sel_ok) begin
          vld_d  = 1'b1;
          act_d  = 1'b1;
          wr_d   = ~rd_nwr;
          addr_d = addr;
          be_d   = ~bw_n;
        end else begin
          vld_d = 1'b0;
          act_d = 1'b0;
        end
      end else if (act_q) begin
        vld_d  = 1'b1;
        addr_d = burst_addr;
        be_d   = ~bw_n;
      end else begin
        vld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      act_q  <= act_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      be_q   <= be_d;
    end
  end

  assign vld      = vld_q;
  assign wr       = wr_q;
  assign cur_addr = addr_q;
  assign cur_be   = be_q;

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(vld_q) && $stable(wr_q) && $stable(addr_q) && $stable(be_q)));
  p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && !sel_ok) |=> !vld_q);
  p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && sleep) |=> !vld_q);
  p_adv_keeps_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !sleep && adv && act_q) |=> (vld_q && (wr_q == $past(wr_q))));

endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int unsigned AW     = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             ce_a_n,
  input  logic             ce_b,
  input  logic             ce_c_n,
  input  logic             adv,
  input  logic             rd_nwr,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  input  logic             lin_order,
  input  logic             sleep,
  input  logic             oe_n,
  input  logic [DW-1:0]    d_in,
  output logic [DW-1:0]    d_out,
  output logic             d_oe
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             sel_ok;
  logic             vld, wr;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] cur_be;
  logic             commit;
  zt_order_e        ord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign sel_ok = ~ce_a_n & ce_b & ~ce_c_n;
  assign ord    = lin_order ? ORD_INCR : ORD_XOR;

  zt_cmd_pipe #(.AW(AW), .LANES(LANES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cen_n    (cen_n),
    .sleep    (sleep),
    .sel_ok   (sel_ok),
    .adv      (adv),
    .rd_nwr   (rd_nwr),
    .addr     (addr),
    .bw_n     (bw_n),
    .ord      (ord),
    .vld      (vld),
    .wr       (wr),
    .cur_addr (cur_addr),
    .cur_be   (cur_be)
  );

  assign commit = ~cen_n & vld & wr;

  zt_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (commit),
    .be    (cur_be),
    .waddr (cur_addr),
    .wdata (d_in),
    .raddr (cur_addr),
    .rdata (d_out)
  );

  assign d_oe = vld & ~wr & ~oe_n;

  p_oe_async_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    oe_n |-> !d_oe);
  p_write_hiz_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cen_n && !sleep && !adv && sel_ok && !rd_nwr) |=> !d_oe);
  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cen_n && !sleep && !adv && sel_ok && rd_nwr && !oe_n) |=> (d_oe || oe_n));

endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 8, LANES = 4, LANE_W = 9, DW = 36, DEPTH = 256;
  localparam logic [2:0] SEL = 3'b010; // {ce_a_n, ce_b, ce_c_n} all asserted

  logic clk = 1'b0, rst_n;
  logic cen_n, ce_a_n, ce_b, ce_c_n, adv, rd_nwr, lin_order, sleep, oe_n, d_oe;
  logic [AW-1:0] addr;
  logic [LANES-1:0] bw_n;
  logic [DW-1:0] d_in, d_out;

  always #4 clk = ~clk;

  zt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .adv(adv), .rd_nwr(rd_nwr), .addr(addr), .bw_n(bw_n),
    .lin_order(lin_order), .sleep(sleep), .oe_n(oe_n), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe));

  int vectors = 0, miscompares = 0;
  string req = "R13";
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_vld = 0, m_wr = 0, m_act = 0;
  logic [AW-1:0] m_addr = '0, m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [LANES-1:0] m_be = '0;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(64'(a) * 64'h9_E377_9B97 + 64'(salt) * 64'h1_0F3D + 64'h5A5);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // One cycle: apply inputs, check the outputs of this cycle, advance the model.
  task automatic tick(input bit cen, input logic [2:0] sel, input bit a_dv, input bit rnw,
                      input int a, input logic [LANES-1:0] ben, input bit oen, input bit slp,
                      input logic [DW-1:0] din);
    logic exp_oe;
    logic [1:0] n;
    @(negedge clk);
    cen_n = cen; {ce_a_n, ce_b, ce_c_n} = sel; adv = a_dv; rd_nwr = rnw;
    addr = AW'(a); bw_n = ben; oe_n = oen; sleep = slp; d_in = din;
    #1;
    exp_oe = m_vld & ~m_wr & ~oen;
    chk(d_oe === exp_oe, "d_oe", DW'(d_oe), DW'(exp_oe));
    if (exp_oe) chk(d_out === ref_mem[m_addr], "d_out", d_out, ref_mem[m_addr]);
    if (!cen) begin
      if (m_vld && m_wr)
        for (int k = 0; k < LANES; k++)
          if (m_be[k]) ref_mem[m_addr][k*LANE_W +: LANE_W] = din[k*LANE_W +: LANE_W];
      if (slp) begin m_vld = 0; m_act = 0; end
      else if (!a_dv) begin
        if (sel == SEL) begin
          m_vld = 1; m_act = 1; m_wr = ~rnw; m_addr = AW'(a); m_be = ~ben;
          m_base = AW'(a); m_cnt = 0;
        end else begin m_vld = 0; m_act = 0; end
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1;
        n = lin_order ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
        m_addr = {m_base[AW-1:2], n}; m_vld = 1; m_be = ~ben;
      end else m_vld = 0;
    end
  endtask

  task automatic idle(input logic [DW-1:0] din);
    tick(0, 3'b111, 0, 1, 0, '1, 0, 0, din);
  endtask
  task automatic rd(input int a, input logic [DW-1:0] din);
    tick(0, SEL, 0, 1, a, '1, 0, 0, din);
  endtask
  task automatic wrc(input int a, input logic [LANES-1:0] ben, input logic [DW-1:0] din);
    tick(0, SEL, 0, 0, a, ben, 0, 0, din);
  endtask

  initial begin
    #1600000;
    miscompares++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; cen_n = 1; {ce_a_n, ce_b, ce_c_n} = 3'b111; adv = 0; rd_nwr = 1;
    addr = '0; bw_n = '1; lin_order = 1; sleep = 0; oe_n = 0; d_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    // R13: idle after reset
    req = "R13"; idle('0); idle('0);

    // R1 R2 R7 R12: write each address, read it the next cycle
    req = "R12";
    for (int a = 0; a < DEPTH; a++) begin
      wrc(a, '0, '0);
      rd(a, pat(a, 1));
    end
    idle('0);

    // R8: all sixteen lane masks over the filled background
    req = "R8";
    for (int k = 0; k < 16; k++) begin
      wrc(k, LANES'(k), '0);
      idle(pat(k, 7));
    end
    for (int k = 0; k < 16; k++) rd(k, '0);
    idle('0);

    // R3: oe_n high blanks a read data cycle at once
    req = "R3";
    rd(5, '0);
    tick(0, 3'b111, 0, 1, 0, '1, 1, 0, '0);
    rd(5, '0);
    idle('0);

    // R4: stall during a read and during a write data cycle
    req = "R4";
    rd(9, '0);
    for (int i = 0; i < 3; i++) tick(1, SEL, 0, 0, 20 + i, '0, 0, 0, pat(i, 99));
    wrc(30, '0, '0);
    for (int i = 0; i < 2; i++) tick(1, SEL, 0, 1, 40, '1, 0, 0, pat(i, 55));
    idle(pat(30, 3));
    rd(30, '0); rd(40, '0); rd(20, '0); idle('0);

    // R5: each chip select alone deselects; pending transfer completes
    req = "R5";
    for (int s = 0; s < 3; s++) begin
      rd(1, '0);
      tick(0, SEL ^ (3'b100 >> s), 0, 1, 2, '1, 0, 0, '0);
      wrc(50 + s, '0, '0);
      tick(0, SEL ^ (3'b100 >> s), 0, 0, 60, '0, 0, 0, pat(s, 11));
      idle('0);
      rd(50 + s, '0); rd(60, '0); idle('0);
    end

    // R6 R7: read, write, read alternation
    req = "R6";
    rd(3, '0); wrc(4, '0, '0); rd(4, pat(4, 21)); wrc(3, '0, '0); rd(3, pat(3, 22)); idle('0);

    // R9: read bursts from every offset in both orders, through the wrap
    req = "R9";
    for (int o = 0; o < 2; o++) begin
      lin_order = o[0];
      for (int st = 0; st < 4; st++) begin
        rd(64 + 8 * o + st, '0);
        for (int b = 0; b < 4; b++) tick(0, 3'b111, 1, 0, 0, '1, 0, 0, '0);
        idle('0);
      end
    end

    // R10: write burst ignores rd_nwr on advance; advance when idle stays idle
    req = "R10";
    for (int o = 0; o < 2; o++) begin
      lin_order = o[0];
      for (int st = 0; st < 4; st++) begin
        wrc(100 + 4 * (4 * o + st) + st, '0, '0);
        for (int b = 0; b < 3; b++) tick(0, SEL, 1, 1, 0, '0, 0, 0, pat(b + 8 * st, 33 + o));
        idle(pat(3, 44 + st));
        rd(100 + 4 * (4 * o + st) + st, '0);
        for (int b = 0; b < 3; b++) tick(0, 3'b111, 1, 0, 0, '1, 0, 0, '0);
        idle('0);
      end
    end
    idle('0);
    tick(0, 3'b111, 1, 1, 0, '1, 0, 0, '0);
    tick(0, SEL, 1, 1, 7, '1, 0, 0, '0);
    idle('0);

    // R11: sleep ignores commands, keeps data, completes pending write
    req = "R11";
    lin_order = 1;
    wrc(200, '0, '0);
    tick(0, SEL, 0, 0, 201, '0, 0, 1, pat(200, 5));
    tick(0, SEL, 0, 1, 202, '1, 0, 1, pat(201, 5));
    tick(0, SEL, 1, 1, 0, '1, 0, 1, '0);
    rd(200, '0); rd(201, '0); rd(202, '0); idle('0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule